// File: doc/BRIEF.md
# Serial Command Shift Front End

This block is the slave side of a four-wire serial link. It runs in the system clock domain: the serial clock, chip select and data input are treated as synchronous, sampled signals, and their edges are found by comparing each sample with the one before. While chip select is low, each rising serial-clock edge shifts the data input into a 16-bit shift register, most significant bit first. Each falling edge drives the register's top bit onto the data output. A bit therefore reappears on the output fifteen and a half serial clocks after it entered, which lets several of these blocks share one select line as a daisy chain.

When chip select rises, the block takes whatever 16 bits the register then holds as a command word. It raises a one-cycle write or read strobe toward a register bank, together with the address field and the data field. On a read, the byte the bank returns replaces the register's low byte. That byte then leaves on the data output as the second eight bits of the next frame.

Top module: `spi_cmd_shifter`

## Requirements
- R1: A command word has a read flag in bit 15 (1 = read, 0 = write), the address in bits 14..8 and the data in bits 7..0, and it is shifted in most significant bit first. On a write, `bank_wr` is high for exactly one clock, starting one clock after chip select is sampled high following a low sample, with `bank_addr` and `bank_wdata` taken from that word.
- R2: While `spi_csn` is high, activity on `spi_sclk` and `spi_din` changes neither the shift register nor `spi_dout`, and it raises no strobe.
- R3: A read word raises `bank_rd` for exactly one clock with `bank_addr` set to its address. The byte on `bank_rdata` during that clock replaces shift-register bits 7..0, and the data byte of the read word is discarded.
- R4: `spi_dout` changes only when `spi_csn` is first sampled low (it then shows register bit 15) or on a falling serial-clock edge while selected. A bit shifted in on rising edge k is sampled on `spi_dout` by the master at rising edge k+16.
- R5: Whatever the number of bits clocked during one select window, the word latched when chip select rises is the last 16 bits shifted in, including bits left over from earlier frames.
- R6: `bank_wr` and `bank_rd` are never high together, and neither stays high for two consecutive clocks.
- R7: After reset the shift register is all zeros, `spi_dout` is low and both strobes are low.
- R8: If a rising serial-clock edge, with chip select low, falls in the same clock as the `bank_rd` strobe, the returned byte is loaded first and the shift is applied on top of it, so no read data is lost.
- R9: `spi_dout` is always driven to 0 or 1; it has no high-impedance state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock, sampled by clk |
| spi_csn | input | 1 | Active-low chip select, sampled by clk |
| spi_din | input | 1 | Serial data input |
| spi_dout | output | 1 | Serial data output, always driven |
| bank_wr | output | 1 | One-cycle write strobe |
| bank_rd | output | 1 | One-cycle read strobe |
| bank_addr | output | 7 | Command address |
| bank_wdata | output | 8 | Command data byte |
| bank_rdata | input | 8 | Register byte returned during bank_rd |

## Verification
The readback load and a serial shift can land in the same clock. This happens when a master drops chip select and raises the serial clock immediately after ending a read frame. The bench provokes it by driving chip select low and the clock high in the cycle right after a read frame ends, so the first shift of the new frame coincides with `bank_rd`. It judges the result by checking that the returned byte still arrives intact in the second half of that frame's output stream.

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              bank_wr,
  output logic              bank_rd,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  input  logic [DATA_W-1:0] bank_rdata
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int MSB     = FRAME_W - 1;

  logic               sclk_q, csn_q;
  logic [FRAME_W-1:0] sr, sr_ld;
  logic               cs_rise, cs_fall, sclk_rise, sclk_fall;

  assign cs_rise   =  spi_csn & ~csn_q;
  assign cs_fall   = ~spi_csn &  csn_q;
  assign sclk_rise = ~spi_csn &  spi_sclk & ~sclk_q;
  assign sclk_fall = ~spi_csn & ~spi_sclk &  sclk_q;

  // readback load is applied first, the shift rides on top of it
  assign sr_ld = bank_rd ? {sr[MSB:DATA_W], bank_rdata} : sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= spi_sclk;
      csn_q  <= spi_csn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sr_ld[MSB-1:0], spi_din};
    else                sr <= sr_ld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   spi_dout <= 1'b0;
    else if (cs_fall | sclk_fall) spi_dout <= sr[MSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_wr    <= 1'b0;
      bank_rd    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      bank_wr <= cs_rise & ~sr[MSB];
      bank_rd <= cs_rise &  sr[MSB];
      if (cs_rise) begin
        bank_addr  <= sr[MSB-1:DATA_W];
        bank_wdata <= sr[DATA_W-1:0];
      end
    end
  end

  a_r1_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> (bank_wdata == $past(sr[DATA_W-1:0]) && bank_addr == $past(sr[MSB-1:DATA_W])));

  a_r1_strobe_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> $past(cs_rise));

  a_r2_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_csn) && !$past(bank_rd)) |-> $stable(sr));

  a_r3_read_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bank_rd) && !$past(sclk_rise)) |-> sr[DATA_W-1:0] == $past(bank_rdata));

  a_r4_dout_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sclk_fall) && !$past(cs_fall)) |-> $stable(spi_dout));

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_wr, bank_rd}));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |=> !(bank_wr || bank_rd));

  a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bank_rd) && $past(sclk_rise)) |-> sr[DATA_W:1] == $past(bank_rdata));

  a_r9_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(spi_dout));
endmodule

// File: tb/spi_cmd_shifter_test.sv
module spi_cmd_shifter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic       dout, bank_wr, bank_rd;
  logic [6:0] bank_addr;
  logic [7:0] bank_wdata, bank_rdata;

  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0, stb_err = 0;
  logic [6:0] last_addr = '0;
  logic [7:0] last_data = '0;
  logic       prev_stb = 1'b0;
  logic [7:0] mem [128];

  always #2 clk = ~clk;

  spi_cmd_shifter uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_din(din),
    .spi_dout(dout), .bank_wr(bank_wr), .bank_rd(bank_rd),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  assign bank_rdata = mem[bank_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
      prev_stb <= 1'b0;
    end else begin
      if (bank_wr && bank_rd) stb_err++;
      if ((bank_wr || bank_rd) && prev_stb) stb_err++;
      prev_stb <= bank_wr | bank_rd;
      if (bank_wr) begin
        wr_cnt++;
        mem[bank_addr] <= bank_wdata;
        last_addr <= bank_addr;
        last_data <= bank_wdata;
      end
      if (bank_rd) begin
        rd_cnt++;
        last_addr <= bank_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, input bit collide,
                      input int tail, output logic [31:0] rx);
    rx = '0;
    @(negedge clk);
    csn = 1'b0;
    if (collide) begin
      din  = tx[n-1];
      sclk = 1'b1;
    end
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (!(collide && i == 0)) begin
        din = tx[n-1-i];
        repeat (2) @(negedge clk);
        rx[n-1-i] = dout;
        sclk = 1'b1;
      end
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    csn = 1'b1;
    repeat (tail) @(negedge clk);
  endtask

  // {tx word, expected readback in that frame}
  localparam logic [31:0] VEC [7] = '{
    {16'h0355, 16'h0000},
    {16'h0A3C, 16'h0355},
    {16'h8300, 16'h0A3C},
    {16'h8A11, 16'h8355},
    {16'h7FC3, 16'h8A3C},
    {16'hFF00, 16'h7FC3},
    {16'h0000, 16'hFFC3}
  };

  logic [31:0] rx;
  int w0, r0;
  logic d0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset dout/strobes", {dout, bank_wr, bank_rd}, 0);

    for (int k = 0; k < 7; k++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      xfer({16'h0, VEC[k][31:16]}, 16, 1'b0, 4, rx);
      chk(k == 0 ? "R7 first frame zeros" : (VEC[k-1][31] ? "R3 readback" : "R4 echo"),
          rx, {16'h0, VEC[k][15:0]});
      if (VEC[k][31])
        chk("R3 read strobe", {wr_cnt - w0, rd_cnt - r0, 25'(last_addr)},
            {32'd0, 32'd1, 25'(VEC[k][30:24])});
      else
        chk("R1 write strobe", {wr_cnt - w0, rd_cnt - r0, 17'(last_addr), last_data},
            {32'd1, 32'd0, 17'(VEC[k][30:24]), VEC[k][23:16]});
    end

    // R2: deselected activity
    xfer(32'h1234, 16, 1'b0, 4, rx);
    chk("R4 echo", rx, 32'h0000);
    w0 = wr_cnt; r0 = rd_cnt; d0 = dout;
    for (int i = 0; i < 6; i++) begin
      din = i[0]; sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
      if (dout !== d0) begin
        chk("R2 dout held", {31'h0, dout}, {31'h0, d0});
      end
    end
    chk("R2 no strobe", {wr_cnt - w0, rd_cnt - r0}, 0);
    xfer(32'hA5678, 20, 1'b0, 4, rx);
    chk("R2 register held", rx[19:4], 32'h1234);
    chk("R4 15.5 delay", rx[3:0], 32'hA);
    chk("R5 long frame latch", {17'(last_addr), last_data}, {17'h56, 8'h78});

    xfer(32'h9A, 8, 1'b0, 4, rx);
    chk("R5 short frame out", rx[7:0], 32'h56);
    chk("R5 short frame latch", {17'(last_addr), last_data}, {17'h78, 8'h9A});
    xfer(32'h0000, 16, 1'b0, 4, rx);
    chk("R5 residue", rx, 32'h789A);

    // R8: shift coincides with the readback load
    xfer(32'h21E7, 16, 1'b0, 4, rx);
    r0 = rd_cnt;
    xfer(32'hA100, 16, 1'b0, 0, rx);
    xfer(32'h0000, 16, 1'b1, 4, rx);
    chk("R8 collision byte", rx[7:0], 32'hE7);
    chk("R8 read strobe", {rd_cnt - r0, 25'(last_addr)}, {32'd1, 25'h00});

    chk("R6 strobe shape", stb_err, 0);
    chk("R9 dout driven", {31'h0, $isunknown(dout)}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule